// File: doc/BRIEF.md
# Dual-Resolution PWM Generator with Mode Hysteresis

This block turns a 16-bit duty setpoint into a single PWM output pin. It picks one of two output modes from the setpoint. Large setpoints use a fast mode: an 8-bit PWM that advances one step per clock, so its period is 256 cycles. Small setpoints use a slow mode instead. That mode runs a long counter, a prescale stage and an 8-bit stage together, and drives the pin high for a number of cycles that tracks the setpoint almost one to one. This lets small duty values keep fine resolution.

A hysteresis band sits between the two mode thresholds. It stops the block from toggling modes when the setpoint sits near the boundary. A configurable percentage limits the fast-mode duty. A parameter can invert the output polarity. A fault input, sampled together with a setpoint write, stops the output at once and returns the block to its post-reset state.

A setpoint write is taken at once and can be read back whole. It reaches the output only at the next period boundary. When no mode is active yet, it reaches the output on the next cycle instead.

Top module: `pwm_dualres`

## Requirements
- R1: After reset, `mode_o` reads 0 (unknown), `sp_rd_o` reads 0, and `pwm_o` sits at the idle level. The idle level is 0, or 1 when `INVERT` is set.
- R2: A write (`sp_wr_i` high, `fault_i` low) stores the full 16-bit `sp_i`. `sp_rd_o` shows that value on the cycle after the write.
- R3: When an applied setpoint is above `THRES + HYST` (0x0BFF by default), or is exactly 0, the block selects fast mode. `mode_o` then reads 2.
- R4: When an applied setpoint is at or below `THRES - HYST` (0x07FF by default), the block selects slow mode (`mode_o` = 1). It also selects slow mode for any nonzero setpoint in the band while the mode is still unknown.
- R5: When a setpoint in the band (0x0800 to 0x0BFF) is applied while the mode is already fast or slow, that mode is kept.
- R6: Fast mode has a period of 256 cycles. The active-level time is floor(sp × L / 65535) cycles, where L = floor(255 × `LIMIT_PCT` / 100).
- R7: When the computed fast duty is zero, the pin holds its idle level steadily.
- R8: Slow mode has a period of 2^(`PRE_W`+8) cycles. The active-level time is floor(sp × `CAL_MUL` / `CAL_DIV`) cycles. That value is first clamped to 65535 and then clamped to the period minus 1.
- R9: A write made while a period is running takes effect only at the end of that period. The pulse already in progress finishes with its old length.
- R10: A write with `fault_i` high has three effects. On the next cycle `sp_rd_o` reads 0 and `mode_o` reads 0, and from then on the pin holds the idle level until a later fault-free write.
- R11: With `INVERT` set, the pin's idle level is 1 and the active level is 0. The active-level time follows R6 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sp_wr_i | input | 1 | Setpoint write strobe |
| sp_i | input | SP_W | Setpoint value to write |
| fault_i | input | 1 | Critical fault, acted on together with a write |
| sp_rd_o | output | SP_W | Last accepted setpoint |
| mode_o | output | 2 | Mode: 0 unknown, 1 slow, 2 fast |
| pwm_o | output | 1 | PWM output pin |

## Verification
A wrong mode register shows up at `mode_o` about one period after the write is applied. It also changes the pin's period from 256 to 2^(PRE_W+8) cycles or the reverse, which a single pulse measurement exposes. A corrupted compare or high-time register shows as a wrong active-level width within two periods. A stuck pending flag shows as a setpoint that appears on `sp_rd_o` but never reaches the mode or the pulse width. The bench probes both hysteresis edges, the zero setpoint, a write in the middle of a pulse, and a fault write. It also drives random setpoints through a model of the mode choice.

// File: rtl/pwm_dr_pkg.sv
// Package: shared mode encoding for the dual-resolution PWM generator.
// Assumes: the encoding is visible at the top-level mode port.
package pwm_dr_pkg;

    typedef enum logic [1:0] {
        MODE_UNKNOWN = 2'd0,
        MODE_SLOW    = 2'd1,
        MODE_FAST    = 2'd2
    } pwm_mode_e;

endpackage

// File: rtl/pwm_dr_sp_latch.sv
// Module: setpoint capture register.
// Holds the last accepted setpoint and a pending flag. A fault on a write
// clears both. The pending flag stays set until the top applies the value.
// Assumes: apply_i is never asserted while a fault write is being taken.
module pwm_dr_sp_latch #(
    parameter int SP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [SP_W-1:0] sp_i,
    input  logic            fault_i,
    input  logic            apply_i,
    output logic [SP_W-1:0] sp_o,
    output logic            pend_o
);

    logic [SP_W-1:0] sp_q;
    logic            pend_q;

    // Capture writes, clear on a fault write, drop the pending flag once applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q   <= '0;
            pend_q <= 1'b0;
        end else if (wr_i && fault_i) begin
            sp_q   <= '0;
            pend_q <= 1'b0;
        end else if (wr_i) begin
            sp_q   <= sp_i;
            pend_q <= 1'b1;
        end else if (apply_i) begin
            pend_q <= 1'b0;
        end
    end

    assign sp_o   = sp_q;
    assign pend_o = pend_q;

    // R2: a clean write is visible whole on the next cycle
    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !fault_i) |=> (sp_o == $past(sp_i)));

endmodule

// File: rtl/pwm_dr_mode_sel.sv
// Module: mode choice with hysteresis and compare-value computation.
// Purely combinational. From a setpoint and the current mode it gives
// the next mode, the limited fast duty and the calibrated slow high time.
// Assumes: HYST <= THRES and CAL_DIV >= 1 (0 is treated as 1).
module pwm_dr_mode_sel
    import pwm_dr_pkg::*;
#(
    parameter int              SP_W      = 16,
    parameter int              DUTY_W    = 8,
    parameter int              HI_W      = 16,
    parameter int              LIMIT_PCT = 100,
    parameter int              CAL_MUL   = 1,
    parameter int              CAL_DIV   = 1,
    parameter logic [SP_W-1:0] THRES     = 16'h09FF,
    parameter logic [SP_W-1:0] HYST      = 16'h0200
) (
    input  logic [SP_W-1:0]   sp_i,
    input  pwm_mode_e         cur_mode_i,
    output pwm_mode_e         next_mode_o,
    output logic [DUTY_W-1:0] duty_o,
    output logic [HI_W-1:0]   hi_o
);

    localparam int P1_W     = SP_W + DUTY_W;
    localparam int P2_W     = SP_W + 16;
    localparam int DUTY_MAX = (1 << DUTY_W) - 1;
    localparam int POSLIM   = (DUTY_MAX * LIMIT_PCT) / 100;
    localparam int SP_MAX   = (1 << SP_W) - 1;
    localparam int MUL_EFF  = (CAL_MUL > 65535) ? 65535 : CAL_MUL;
    localparam int DIV_RAW  = (CAL_DIV > 65535) ? 65535 : CAL_DIV;
    localparam int DIV_EFF  = (DIV_RAW < 1) ? 1 : DIV_RAW;
    localparam int HI_MAX   = (1 << HI_W) - 1;
    localparam int HI_LIM   = (HI_MAX < 65535) ? HI_MAX : 65535;

    localparam logic [SP_W-1:0] UP_EDGE = THRES + HYST;
    localparam logic [SP_W-1:0] LO_EDGE = THRES - HYST;

    logic [P1_W-1:0] duty_prod;
    logic [P1_W-1:0] duty_quot;
    logic [P2_W-1:0] hi_prod;
    logic [P2_W-1:0] hi_quot;

    // Pick the mode: above the band or zero goes fast, below it or from unknown goes slow.
    always_comb begin
        if ((sp_i > UP_EDGE) || (sp_i == '0)) begin
            next_mode_o = MODE_FAST;
        end else if ((sp_i <= LO_EDGE) || (cur_mode_i == MODE_UNKNOWN)) begin
            next_mode_o = MODE_SLOW;
        end else begin
            next_mode_o = cur_mode_i;
        end
    end

    // Scale the setpoint into the limited fast duty range.
    always_comb begin
        duty_prod = {{DUTY_W{1'b0}}, sp_i} * P1_W'(POSLIM);
        duty_quot = duty_prod / P1_W'(SP_MAX);
        duty_o    = (duty_quot > P1_W'(POSLIM)) ? DUTY_W'(POSLIM)
                                                : duty_quot[DUTY_W-1:0];
    end

    // Apply calibration to the setpoint and clamp to 16 bits and the slow period.
    always_comb begin
        hi_prod = {16'd0, sp_i} * P2_W'(MUL_EFF);
        hi_quot = hi_prod / P2_W'(DIV_EFF);
        hi_o    = (hi_quot > P2_W'(HI_LIM)) ? HI_W'(HI_LIM)
                                            : hi_quot[HI_W-1:0];
    end

endmodule

// File: rtl/pwm_dr_timer.sv
// Module: shared period counter and output comparator.
// Fast mode wraps the low FAST_W bits every 2^FAST_W cycles. Slow mode wraps
// the full CNT_W bits. On a mode change the counter restarts from 0 when
// INVERT is set, and from all ones of the new width otherwise.
// Assumes: CNT_W > FAST_W. The compare and high-time inputs change only at a wrap.
module pwm_dr_timer #(
    parameter int   FAST_W = 8,
    parameter int   CNT_W  = 16,
    parameter logic INVERT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              fast_i,
    input  logic              restart_i,
    input  logic              restart_fast_i,
    input  logic [FAST_W-1:0] cmp_i,
    input  logic [CNT_W-1:0]  hi_i,
    input  logic              zero_i,
    output logic              wrap_o,
    output logic              pin_o
);

    localparam logic [CNT_W-1:0] ONES_SLOW = '1;
    localparam logic [CNT_W-1:0] ONES_FAST = CNT_W'((1 << FAST_W) - 1);
    localparam logic             IDLE_LVL  = INVERT;

    logic [CNT_W-1:0] cnt_q;
    logic             pin_q;
    logic             act_fast;
    logic             act_slow;
    logic             pin_d;

    // Flag the last cycle of the running period.
    always_comb begin
        if (!run_i) begin
            wrap_o = 1'b0;
        end else if (fast_i) begin
            wrap_o = (cnt_q[FAST_W-1:0] == '1);
        end else begin
            wrap_o = (cnt_q == ONES_SLOW);
        end
    end

    // Advance, wrap, hold at zero when stopped, or reload on a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            if (INVERT) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= restart_fast_i ? ONES_FAST : ONES_SLOW;
            end
        end else if (!run_i || wrap_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Compare the counter against the stored values to get the active level.
    always_comb begin
        act_fast = INVERT ? (cnt_q[FAST_W-1:0] < cmp_i)
                          : (cnt_q[FAST_W-1:0] > cmp_i);
        act_slow = (cnt_q < hi_i);
        if (!run_i) begin
            pin_d = IDLE_LVL;
        end else if (fast_i) begin
            pin_d = zero_i ? IDLE_LVL : (act_fast ^ INVERT);
        end else begin
            pin_d = act_slow ^ INVERT;
        end
    end

    // Register the pin so it changes cleanly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= IDLE_LVL;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign pin_o = pin_q;

    // R10: a stopped counter leaves the pin idle on the next cycle
    assert_idle_when_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (pin_o == IDLE_LVL));

    // R6: the fast period uses only the low FAST_W bits
    assert_fast_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && fast_i) |-> ((cnt_q >> FAST_W) == '0));

endmodule

// File: rtl/pwm_dualres.sv
// Module: top of the dual-resolution PWM generator.
// Ties the setpoint latch, mode selector and timer together. A pending
// setpoint is applied at the end of the running period, or on the next
// cycle while no mode is active. A fault write stops the block immediately.
// Assumes: fault_i matters only in cycles where sp_wr_i is high.
module pwm_dualres
    import pwm_dr_pkg::*;
#(
    parameter int              SP_W      = 16,
    parameter int              FAST_W    = 8,
    parameter int              PRE_W     = 8,
    parameter int              LIMIT_PCT = 100,
    parameter logic            INVERT    = 1'b0,
    parameter int              CAL_MUL   = 1,
    parameter int              CAL_DIV   = 1,
    parameter logic [SP_W-1:0] THRES     = 16'h09FF,
    parameter logic [SP_W-1:0] HYST      = 16'h0200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sp_wr_i,
    input  logic [SP_W-1:0] sp_i,
    input  logic            fault_i,
    output logic [SP_W-1:0] sp_rd_o,
    output logic [1:0]      mode_o,
    output logic            pwm_o
);

    localparam int CNT_W = PRE_W + FAST_W;
    localparam logic [SP_W-1:0] BAND_HI = THRES + HYST;
    localparam logic [SP_W-1:0] BAND_LO = THRES - HYST;

    pwm_mode_e         mode_q;
    pwm_mode_e         mode_nx;
    logic [SP_W-1:0]   acc_sp;
    logic              pend;
    logic              fault_hit;
    logic              apply;
    logic              restart;
    logic              wrap;
    logic [FAST_W-1:0] duty_c;
    logic [CNT_W-1:0]  hi_c;
    logic [FAST_W-1:0] cmp_q;
    logic [CNT_W-1:0]  hi_q;
    logic              zero_q;

    assign fault_hit = sp_wr_i && fault_i;
    assign apply     = pend && !fault_hit && ((mode_q == MODE_UNKNOWN) || wrap);
    assign restart   = apply && (mode_nx != mode_q);

    pwm_dr_sp_latch #(
        .SP_W (SP_W)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (sp_wr_i),
        .sp_i    (sp_i),
        .fault_i (fault_i),
        .apply_i (apply),
        .sp_o    (acc_sp),
        .pend_o  (pend)
    );

    pwm_dr_mode_sel #(
        .SP_W      (SP_W),
        .DUTY_W    (FAST_W),
        .HI_W      (CNT_W),
        .LIMIT_PCT (LIMIT_PCT),
        .CAL_MUL   (CAL_MUL),
        .CAL_DIV   (CAL_DIV),
        .THRES     (THRES),
        .HYST      (HYST)
    ) u_sel (
        .sp_i        (acc_sp),
        .cur_mode_i  (mode_q),
        .next_mode_o (mode_nx),
        .duty_o      (duty_c),
        .hi_o        (hi_c)
    );

    // Hold mode and compare values; load them on apply, drop them on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_UNKNOWN;
            cmp_q  <= INVERT ? '0 : '1;
            hi_q   <= '0;
            zero_q <= 1'b1;
        end else if (fault_hit) begin
            mode_q <= MODE_UNKNOWN;
            cmp_q  <= INVERT ? '0 : '1;
            hi_q   <= '0;
            zero_q <= 1'b1;
        end else if (apply) begin
            mode_q <= mode_nx;
            cmp_q  <= INVERT ? duty_c : ~duty_c;
            hi_q   <= hi_c;
            zero_q <= (duty_c == '0);
        end
    end

    pwm_dr_timer #(
        .FAST_W (FAST_W),
        .CNT_W  (CNT_W),
        .INVERT (INVERT)
    ) u_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .run_i          (mode_q != MODE_UNKNOWN),
        .fast_i         (mode_q == MODE_FAST),
        .restart_i      (restart),
        .restart_fast_i (mode_nx == MODE_FAST),
        .cmp_i          (cmp_q),
        .hi_i           (hi_q),
        .zero_i         (zero_q),
        .wrap_o         (wrap),
        .pin_o          (pwm_o)
    );

    assign sp_rd_o = acc_sp;
    assign mode_o  = mode_q;

    // R3: the mode register never holds the unused code
    assert_mode_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);

    // R10: a fault write clears the readback and the mode
    assert_fault_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit |=> ((sp_rd_o == '0) && (mode_o == 2'd0)));

    // R5: a band setpoint applied with a known mode keeps that mode
    assert_band_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && (mode_q != MODE_UNKNOWN) && (acc_sp > BAND_LO) && (acc_sp <= BAND_HI))
        |=> (mode_o == $past(mode_o)));

    // R9: compare values change only at a period end, from unknown, or on a fault
    assert_apply_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && (mode_q != MODE_UNKNOWN) && !fault_hit)
        |=> ($stable(cmp_q) && $stable(hi_q)));

endmodule

// File: tb/pwm_dualres_tb.sv
module pwm_dualres_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sp_wr = 1'b0;
    logic [15:0] sp = '0;
    logic        fault = 1'b0;
    logic [15:0] rd, rd_inv;
    logic [1:0]  mode, mode_inv;
    logic        pwm, pwm_inv;

    int total = 0;
    int bad = 0;
    int mm = 0;    // model mode: 0 unknown, 1 slow, 2 fast
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_dualres #(.PRE_W(4), .LIMIT_PCT(80), .CAL_MUL(5), .CAL_DIV(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .sp_wr_i(sp_wr), .sp_i(sp), .fault_i(fault),
        .sp_rd_o(rd), .mode_o(mode), .pwm_o(pwm));

    pwm_dualres #(.PRE_W(4), .LIMIT_PCT(80), .CAL_MUL(5), .CAL_DIV(4), .INVERT(1'b1)) u_inv (
        .clk(clk), .rst_n(rst_n), .sp_wr_i(sp_wr), .sp_i(sp), .fault_i(fault),
        .sp_rd_o(rd_inv), .mode_o(mode_inv), .pwm_o(pwm_inv));

    function automatic int m_duty(int s);
        return (s * 204) / 65535;
    endfunction

    function automatic int m_hi(int s);
        int h;
        h = (s * 5) / 4;
        if (h > 65535) h = 65535;
        if (h > 4095) h = 4095;
        return h;
    endfunction

    function automatic int m_mode(int s, int cur);
        if (s > 'h0BFF || s == 0) return 2;
        if (s <= 'h07FF || cur == 0) return 1;
        return cur;
    endfunction

    function automatic bit act(bit inv);
        return inv ? !pwm_inv : pwm;
    endfunction

    task automatic chk(string tag, int actual, int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic do_write(int s, bit f);
        @(negedge clk);
        sp_wr = 1'b1;
        sp = 16'(s);
        fault = f;
        @(negedge clk);
        sp_wr = 1'b0;
        fault = 1'b0;
    endtask

    // Write a setpoint and wait until it is surely applied; update the model.
    task automatic apply_sp(int s);
        int old;
        old = mm;
        do_write(s, 1'b0);
        repeat ((old == 1) ? 4110 : (old == 2) ? 270 : 4) @(negedge clk);
        mm = m_mode(s, old);
    endtask

    task automatic wait_rise(bit inv);
        bit prev;
        prev = act(inv);
        forever begin
            @(negedge clk);
            if (act(inv) && !prev) break;
            prev = act(inv);
        end
    endtask

    task automatic measure(bit inv, output int hi, output int per);
        int lo;
        hi = 0;
        lo = 0;
        wait_rise(inv);
        wait_rise(inv);
        while (act(inv)) begin hi++; @(negedge clk); end
        while (!act(inv)) begin lo++; @(negedge clk); end
        per = hi + lo;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int h, p, cnt, s, r;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 mode", int'(mode), 0);
        chk("R1 readback", int'(rd), 0);
        chk("R1 pin", int'(pwm), 0);
        chk("R11 inverted idle", int'(pwm_inv), 1);

        // R4 band value from unknown selects slow; R2 readback
        apply_sp('h0900);
        chk("R2 readback", int'(rd), 'h0900);
        chk("R4 mode from unknown", int'(mode), 1);
        measure(1'b0, h, p);
        chk("R8 slow high", h, m_hi('h0900));
        chk("R8 slow period", p, 4096);

        // R5 upper band edge keeps slow
        apply_sp('h0BFF);
        chk("R5 hold slow at 0BFF", int'(mode), 1);
        measure(1'b0, h, p);
        chk("R8 slow high 0BFF", h, m_hi('h0BFF));

        // R3 just above the band goes fast
        apply_sp('h0C00);
        chk("R3 fast at 0C00", int'(mode), 2);
        measure(1'b0, h, p);
        chk("R6 fast high 0C00", h, m_duty('h0C00));
        chk("R6 fast period", p, 256);

        // R5 lower band edge keeps fast
        apply_sp('h0800);
        chk("R5 hold fast at 0800", int'(mode), 2);
        measure(1'b0, h, p);
        chk("R6 fast high 0800", h, m_duty('h0800));

        // R4 just below the band goes slow
        apply_sp('h07FF);
        chk("R4 slow at 07FF", int'(mode), 1);

        // R3/R7 zero goes fast with a static idle pin
        apply_sp(0);
        chk("R3 fast at zero", int'(mode), 2);
        cnt = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (pwm || !pwm_inv) cnt++;
        end
        chk("R7 static idle", cnt, 0);

        // R6 full scale hits the duty limit; R11 inverted active time
        apply_sp('hFFFF);
        measure(1'b0, h, p);
        chk("R6 limit high", h, 204);
        chk("R6 limit period", p, 256);
        measure(1'b1, h, p);
        chk("R11 inverted active", h, 204);
        chk("R11 inverted period", p, 256);

        // R9 write during a pulse: the running pulse keeps its old length
        wait_rise(1'b0);
        h = 0;
        while (pwm) begin
            h++;
            if (h == 3) begin sp_wr = 1'b1; sp = 16'h4000; end
            if (h == 4) sp_wr = 1'b0;
            @(negedge clk);
        end
        sp_wr = 1'b0;
        chk("R9 old pulse kept", h, 204);
        repeat (270) @(negedge clk);
        measure(1'b0, h, p);
        chk("R9 new pulse", h, m_duty('h4000));

        // R10 fault write
        do_write('h5000, 1'b1);
        chk("R10 readback cleared", int'(rd), 0);
        chk("R10 mode unknown", int'(mode), 0);
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (pwm) cnt++;
        end
        chk("R10 pin idle", cnt, 0);
        mm = 0;
        apply_sp('h0A00);
        chk("R4 band after fault", int'(mode), 1);

        // Random setpoints against the model
        for (int k = 0; k < 14; k++) begin
            r = int'($urandom % 3);
            if (r == 0) s = 'h0C00 + int'($urandom % ('h10000 - 'h0C00));
            else if (r == 1) s = 'h0800 + int'($urandom % 'h400);
            else s = 1 + int'($urandom % 'h07FF);
            apply_sp(s);
            chk("R2 random readback", int'(rd), s);
            chk("R3 R4 R5 random mode", int'(mode), mm);
            if (mm == 2 && m_duty(s) > 0) begin
                measure(1'b0, h, p);
                chk("R6 random high", h, m_duty(s));
                chk("R6 random period", p, 256);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule